// File: doc/BRIEF.md
# Trace Sync and Priority Controller

This block sits in front of a trace message queue. Each cycle it takes request strobes for three message kinds: error, watchpoint and data trace. It picks at most one of them to enter the queue, using a fixed priority. A data-trace message that loses a collision is not held back for a later cycle; it is thrown away.

The block also decides whether a data-trace message that does get through carries the synchronising form. A single pending-sync flag is set by any event that leaves the trace consumer with a gap or a discontinuity. The next data-trace message that enters the queue consumes the flag and goes out in its sync form. The events that set the flag are:

- reset;
- trace being disabled;
- a dropped data-trace message;
- a blocked secure access;
- a queue overrun;
- a mode exit;
- an enabled event-in pulse.

A periodic counter of plain data-trace messages also forces a sync once it reaches its limit.

The outputs are combinational from the current inputs and the two state elements, the flag and the counter. A request is therefore answered in the same cycle. Its effect on the sync state shows from the next cycle on.

Top module: `trace_sync_ctrl`

## Requirements
- R1: With no overrun, an error request always wins, a watchpoint request wins over a data-trace request, and a data-trace request is granted only when neither of the others is present. `enqType` encodes the winner as 0 = none, 1 = error, 2 = watchpoint, 3 = data trace. `enqValid` is high exactly when `enqType` is not 0.
- R2: A data-trace request that loses to an error or watchpoint request in the same cycle produces no message. The next granted data-trace message has `enqSync` = 1.
- R3: After reset is released, the first granted data-trace message has `enqSync` = 1.
- R4: While `traceEn` is 0, a data-trace request is not granted and does not clear the pending sync or advance the counter. The first data-trace message after trace is re-enabled has `enqSync` = 1.
- R5: A `modeExit` pulse makes the next granted data-trace message a sync message.
- R6: An `evtIn` pulse with `evtInEn` = 1 and trace enabled makes the next data-trace message a sync message. With `evtInEn` = 0 it has no effect.
- R7: A data-trace request with `secureHit` = 1 produces no message, and the next granted data-trace message has `enqSync` = 1.
- R8: After SYNC_PERIOD (default 255) consecutive plain data-trace messages, the next data-trace message has `enqSync` = 1.
- R9: Every sync message clears the pending flag and restarts the periodic count from zero, whatever caused it.
- R10: While `qOverrun` is 1, no message of any kind is granted. The next data-trace message after the overrun has `enqSync` = 1.
- R11: `enqSync` is 0 whenever the granted message is not a data-trace message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| traceEn | input | 1 | Data trace enable |
| errReq | input | 1 | Error message request |
| wpReq | input | 1 | Watchpoint message request |
| dtReq | input | 1 | Data-trace message request |
| secureHit | input | 1 | Current data access targets secure memory |
| evtIn | input | 1 | External event-in pulse |
| evtInEn | input | 1 | Enables event-in to force a sync |
| modeExit | input | 1 | Exit from low-power or debug mode |
| qOverrun | input | 1 | Queue overrun in progress |
| enqValid | output | 1 | A message is enqueued this cycle |
| enqType | output | 2 | Type of the enqueued message (0 none, 1 error, 2 watchpoint, 3 data trace) |
| enqSync | output | 1 | Enqueued data-trace message is the sync variant |

## Verification
The bench sweeps all eight request combinations and checks the winner. After each combination it checks that the following data-trace message is sync exactly when a data-trace request lost. A design that queued the loser, or forgot to arm the flag, would emit a plain message after a gap.

The periodic limit is checked at its exact boundary: 255 plain messages, then one sync. A counter that was off by one would produce the sync one message early or late.

A sync caused by a mode exit must also restart the period. A design that reset only the flag would force the next sync too early.

Disabled-trace requests, secure hits, overruns and event-in pulses with and without their enable are each followed by a probe message. A design that let a disabled request consume the flag would emit a plain first message after re-enable.

// File: rtl/trace_sync_pkg.sv
package trace_sync_pkg;

  typedef enum logic [1:0] {
    MSG_NONE = 2'd0,
    MSG_ERR  = 2'd1,
    MSG_WP   = 2'd2,
    MSG_DT   = 2'd3
  } msgType_e;

  // Strobes from arbitration control to the sync state datapath
  typedef struct packed {
    logic dtPlain;  // plain data-trace message enqueued
    logic dtSync;   // sync data-trace message enqueued
    logic arm;      // an event requires the next data-trace message to sync
  } syncStrobe_t;

endpackage

// File: rtl/trace_sync_state.sv
module trace_sync_state
  import trace_sync_pkg::*;
#(
  parameter int SYNC_PERIOD = 255
) (
  input  logic        clk,
  input  logic        rstN,
  input  syncStrobe_t strobe,
  output logic        syncNeed
);
  localparam int CNT_W = $clog2(SYNC_PERIOD + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(SYNC_PERIOD);

  logic             pendSync;
  logic [CNT_W-1:0] plainCnt;
  logic             cntFull;

  assign cntFull  = (plainCnt == CNT_LIMIT);
  assign syncNeed = pendSync | cntFull;

  // Arming takes precedence over clearing in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSync <= 1'b1;
    end else if (strobe.arm) begin
      pendSync <= 1'b1;
    end else if (strobe.dtSync) begin
      pendSync <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      plainCnt <= '0;
    end else if (strobe.dtSync) begin
      plainCnt <= '0;
    end else if (strobe.dtPlain && !cntFull) begin
      plainCnt <= plainCnt + 1'b1;
    end
  end

  AST_ARM_SETS_PEND: assert property (@(posedge clk) disable iff (!rstN)
    strobe.arm |=> pendSync);  // R2
  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.dtSync && !strobe.arm) |=> (!pendSync && plainCnt == '0));  // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    plainCnt <= CNT_LIMIT);  // R8
  AST_PLAIN_ONLY_IF_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dtPlain |-> !syncNeed);  // R8
endmodule

// File: rtl/trace_sync_arb.sv
module trace_sync_arb
  import trace_sync_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        traceEn,
  input  logic        errReq,
  input  logic        wpReq,
  input  logic        dtReq,
  input  logic        secureHit,
  input  logic        evtIn,
  input  logic        evtInEn,
  input  logic        modeExit,
  input  logic        qOverrun,
  input  logic        syncNeed,
  output logic        enqValid,
  output msgType_e    enqType,
  output logic        enqSync,
  output syncStrobe_t strobe
);
  logic dtLive;
  logic dtWin;
  logic evtArm;

  assign dtLive = dtReq & traceEn;
  assign evtArm = evtIn & evtInEn & traceEn;

  always_comb begin
    enqType = MSG_NONE;
    dtWin   = 1'b0;
    if (!qOverrun) begin
      if (errReq) begin
        enqType = MSG_ERR;
      end else if (wpReq) begin
        enqType = MSG_WP;
      end else if (dtLive && !secureHit) begin
        enqType = MSG_DT;
        dtWin   = 1'b1;
      end
    end
  end

  assign enqValid = (enqType != MSG_NONE);
  assign enqSync  = dtWin & syncNeed;

  always_comb begin
    strobe.dtPlain = dtWin & ~syncNeed;
    strobe.dtSync  = dtWin & syncNeed;
    strobe.arm     = ~traceEn | modeExit | evtArm | qOverrun | (dtLive & ~dtWin);
  end

  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (errReq && !qOverrun) |-> enqType == MSG_ERR);  // R1
  AST_WP_SECOND: assert property (@(posedge clk) disable iff (!rstN)
    (wpReq && !errReq && !qOverrun) |-> enqType == MSG_WP);  // R1
  AST_OVERRUN_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    qOverrun |-> !enqValid);  // R10
  AST_SYNC_DT_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    enqSync |-> enqType == MSG_DT);  // R11
  AST_DISABLED_NO_DT: assert property (@(posedge clk) disable iff (!rstN)
    !traceEn |-> enqType != MSG_DT);  // R4
  AST_SECURE_NO_DT: assert property (@(posedge clk) disable iff (!rstN)
    secureHit |-> enqType != MSG_DT);  // R7
endmodule

// File: rtl/trace_sync_ctrl.sv
module trace_sync_ctrl
  import trace_sync_pkg::*;
#(
  parameter int SYNC_PERIOD = 255
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       traceEn,
  input  logic       errReq,
  input  logic       wpReq,
  input  logic       dtReq,
  input  logic       secureHit,
  input  logic       evtIn,
  input  logic       evtInEn,
  input  logic       modeExit,
  input  logic       qOverrun,
  output logic       enqValid,
  output logic [1:0] enqType,
  output logic       enqSync
);
  syncStrobe_t strobe;
  logic        syncNeed;
  msgType_e    typeSel;

  trace_sync_arb uArb (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .errReq(errReq), .wpReq(wpReq),
    .dtReq(dtReq), .secureHit(secureHit), .evtIn(evtIn), .evtInEn(evtInEn),
    .modeExit(modeExit), .qOverrun(qOverrun), .syncNeed(syncNeed),
    .enqValid(enqValid), .enqType(typeSel), .enqSync(enqSync), .strobe(strobe)
  );

  trace_sync_state #(.SYNC_PERIOD(SYNC_PERIOD)) uState (
    .clk(clk), .rstN(rstN), .strobe(strobe), .syncNeed(syncNeed)
  );

  assign enqType = typeSel;

  AST_VALID_MATCHES_TYPE: assert property (@(posedge clk) disable iff (!rstN)
    enqValid == (enqType != 2'd0));  // R1
  AST_MODE_EXIT_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeExit) && dtReq && traceEn && !secureHit && !errReq && !wpReq && !qOverrun)
      |-> enqSync);  // R5
endmodule

// File: tb/trace_sync_ctrl_test.sv
`timescale 1ns/1ps
module trace_sync_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic traceEn = 1'b0, errReq = 1'b0, wpReq = 1'b0, dtReq = 1'b0;
  logic secureHit = 1'b0, evtIn = 1'b0, evtInEn = 1'b0, modeExit = 1'b0, qOverrun = 1'b0;
  logic       enqValid;
  logic [1:0] enqType;
  logic       enqSync;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  trace_sync_ctrl uut (
    .clk(clk), .rstN(rstN), .traceEn(traceEn), .errReq(errReq), .wpReq(wpReq),
    .dtReq(dtReq), .secureHit(secureHit), .evtIn(evtIn), .evtInEn(evtInEn),
    .modeExit(modeExit), .qOverrun(qOverrun),
    .enqValid(enqValid), .enqType(enqType), .enqSync(enqSync)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Inputs are set one ns after a rising edge and outputs sampled one ns later
  task automatic commit();
    @(posedge clk);
    #1;
  endtask

  task automatic dtMsg(input bit expSync, input string req);
    dtReq = 1'b1;
    #1;
    chk(enqValid && enqType == 2'd3, req, {enqValid, enqType}, 7);
    chk(enqSync == expSync, req, enqSync, expSync);
    commit();
    dtReq = 1'b0;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    commit();
    sig = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    traceEn = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(!enqValid, "reset idle", enqValid, 0);
    rstN = 1'b1;

    // R3: first message after reset is sync, then plain
    dtMsg(1'b1, "R3");
    dtMsg(1'b0, "R3");

    // R1, R2, R11: every request combination
    for (int m = 0; m < 8; m++) begin
      int expType;
      dtReq = 1'b1;          // flush any pending sync
      commit();
      dtReq = 1'b0;
      errReq = m[2];
      wpReq  = m[1];
      dtReq  = m[0];
      expType = m[2] ? 1 : (m[1] ? 2 : (m[0] ? 3 : 0));
      #1;
      chk(enqType == expType, "R1", enqType, expType);
      chk(enqValid == (expType != 0), "R1", enqValid, expType != 0);
      if (expType != 3)
        chk(enqSync == 1'b0, "R11", enqSync, 0);
      commit();
      errReq = 1'b0; wpReq = 1'b0; dtReq = 1'b0;
      dtMsg(m[0] && (m[2] || m[1]), "R2");
    end

    // R4: disabled requests ignored, first after re-enable is sync
    traceEn = 1'b0;
    dtReq = 1'b1;
    #1;
    chk(!enqValid, "R4", enqValid, 0);
    commit();
    dtReq = 1'b0;
    traceEn = 1'b1;
    dtMsg(1'b1, "R4");
    dtMsg(1'b0, "R4");

    // R5: mode exit
    pulse(modeExit);
    dtMsg(1'b1, "R5");
    dtMsg(1'b0, "R5");

    // R6: event-in with and without enable
    pulse(evtIn);
    dtMsg(1'b0, "R6");
    evtInEn = 1'b1;
    pulse(evtIn);
    evtInEn = 1'b0;
    dtMsg(1'b1, "R6");

    // R7: secure access suppressed then sync
    secureHit = 1'b1;
    dtReq = 1'b1;
    #1;
    chk(!enqValid, "R7", enqValid, 0);
    commit();
    secureHit = 1'b0;
    dtReq = 1'b0;
    dtMsg(1'b1, "R7");

    // R10: overrun blocks all, then sync
    qOverrun = 1'b1;
    errReq = 1'b1; wpReq = 1'b1; dtReq = 1'b1;
    #1;
    chk(!enqValid, "R10", enqValid, 0);
    commit();
    qOverrun = 1'b0;
    errReq = 1'b0; wpReq = 1'b0; dtReq = 1'b0;
    dtMsg(1'b1, "R10");

    // R8: exactly 255 plain then sync
    for (int i = 0; i < 255; i++) dtMsg(1'b0, "R8");
    dtMsg(1'b1, "R8");

    // R9: sync from mode exit restarts the period
    for (int i = 0; i < 10; i++) dtMsg(1'b0, "R9");
    pulse(modeExit);
    dtMsg(1'b1, "R9");
    for (int i = 0; i < 255; i++) dtMsg(1'b0, "R9");
    dtMsg(1'b1, "R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule